// File: doc/BRIEF.md
# Single-Bit Test, Set, Clear and Invert Unit

This execution unit performs one operation on a single bit of an 8-bit or 16-bit operand. A one-byte opcode tells it which operation to perform, where the bit number comes from and how wide the operand is. The bit number comes from one of two sources: the low nibble of a count register, or a small immediate. The four operations are test, clear, set and invert. The operand is either a register value, which is presented with the start pulse, or a memory word. For a memory word the unit reads the value, modifies it and writes it back.

A start pulse with a legal opcode launches the operation. The unit then stays busy for a fixed number of cycles, which depends on the operation, the index source, the operand width and whether the operand is in memory. It ends with a one-cycle `done` pulse. In that cycle `result` carries the modified operand, and `wb_en` tells the register file to write it back. Only the test operation changes the zero flag. Effective-address generation and prefixes belong to neighbouring blocks. The memory port therefore carries only the data, a write strobe and a width bit.

Top module: `bitop_unit`

## Requirements
- R1: Opcode layout: bits 7:4 must be 0001. Bit 3 selects the index source (1 = immediate, 0 = count register). Bits 2:1 select the operation (00 test, 01 clear, 10 set, 11 invert). Bit 0 selects a word (1) or a byte (0) operand. A start pulse with any other value in bits 7:4 is ignored: `busy` and `done` stay low.
- R2: The bit index is the low 3 bits of the chosen source for a byte operand and the low 4 bits for a word operand. The higher bits are ignored.
- R3: Test leaves the operand unchanged. It writes nothing (no `wb_en`, no memory write). In the cycle after its `done`, `zero` is 1 exactly when the selected bit was 0.
- R4: Clear, set and invert force the selected bit to 0, force it to 1 or flip it, and keep all other bits. For a byte operand, `result` bits 15:8 are 0.
- R5: Register forms raise `done` N cycles after the start cycle. With the count-register index N is 3 for test, 4 for set, 4 for invert and 5 for clear. An immediate index adds one cycle to each.
- R6: Memory forms with a zero-wait memory take the following N (byte/word). With the count-register index: test 12/16, set 13/21, clear 14/22, invert 18/26. With an immediate index: test 13/17, set 14/22, clear 15/27, invert 19/27.
- R7: A memory form performs exactly one read. Every form except test then performs exactly one write, and no other access comes between the two. The write data equals `result`, and `mem_word` equals opcode bit 0 during both accesses.
- R8: `wb_en` is high only in the `done` cycle of a register-form clear, set or invert.
- R9: After reset `busy`, `done`, `mem_req`, `wb_en` and `zero` are 0. `busy` is high from the cycle after launch through the `done` cycle. A start pulse while busy is ignored.
- R10: Clear, set and invert leave `zero` unchanged.
- R11: When the memory inserts wait cycles, each access is held until `mem_ack`. `done` then comes at the later of the R6 count and the cycle after the last acknowledged access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, one cycle |
| opcode | input | 8 | Second opcode byte |
| use_mem | input | 1 | 1 = operand is in memory |
| reg_operand | input | 16 | Register operand, sampled at launch |
| count_idx | input | 4 | Low nibble of the count register |
| imm_idx | input | 4 | Immediate bit index |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access |
| mem_word | output | 1 | 1 = 16-bit access |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access accepted this cycle |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| result | output | 16 | Modified operand, valid with done |
| wb_en | output | 1 | Register write-back strobe |
| zero | output | 1 | Zero flag from the last test |

## Verification
The bench aims at index masking with high source bits set. A design that used the full nibble for a byte operand would change or test the wrong bit, or a bit of the upper byte. It runs all sixteen register forms and all sixteen memory forms and compares the exact `done` cycle against the latency table. A swapped table entry or a missing immediate cycle therefore shows up as a cycle mismatch. Slow-memory cases check that the operation stretches past the table count when the accesses take longer. A start pulse during a busy period must not produce a second completion, and an illegal opcode must never launch. The bench also tracks the zero flag through a series of mixed operations, so a design that let clear, set or invert touch `zero` diverges from the model.

// File: rtl/bitop_pkg.sv
`timescale 1ns/1ps
package bitop_pkg;

   typedef enum logic [1:0] {
      BOP_TEST = 2'b00,
      BOP_CLR  = 2'b01,
      BOP_SET  = 2'b10,
      BOP_INV  = 2'b11
   } bop_e;

   typedef struct packed {
      logic legal;
      logic from_imm;
      bop_e op;
      logic word;
   } bop_ctl_t;

   localparam int unsigned BOP_MAX_CYCLES = 27;

   // Fixed cycle budget per form (zero-wait memory for memory forms).
   function automatic int unsigned bop_cycles(bop_e op, logic from_imm, logic word, logic mem);
      int unsigned n;
      if (!mem) begin
         case (op)
            BOP_TEST: n = 3;
            BOP_CLR:  n = 5;
            default:  n = 4;
         endcase
         n = n + (from_imm ? 1 : 0);
      end else if (!from_imm) begin
         case (op)
            BOP_TEST: n = word ? 16 : 12;
            BOP_SET:  n = word ? 21 : 13;
            BOP_CLR:  n = word ? 22 : 14;
            default:  n = word ? 26 : 18;
         endcase
      end else begin
         case (op)
            BOP_TEST: n = word ? 17 : 13;
            BOP_SET:  n = word ? 22 : 14;
            BOP_CLR:  n = word ? 27 : 15;
            default:  n = word ? 27 : 19;
         endcase
      end
      return n;
   endfunction

endpackage

// File: rtl/bitop_decode.sv
`timescale 1ns/1ps
module bitop_decode
   import bitop_pkg::*;
#(
   parameter int OPC_W = 8
) (
   input  logic [OPC_W-1:0] opcode,
   output bop_ctl_t         ctl
);
   localparam logic [3:0] GROUP_CODE = 4'b0001;

   generate
      if (OPC_W != 8) begin : g_bad_opc
         $error("bitop_decode: OPC_W must be 8");
      end
   endgenerate

   always_comb begin
      ctl.legal    = (opcode[OPC_W-1:OPC_W-4] == GROUP_CODE);
      ctl.from_imm = opcode[3];
      ctl.op       = bop_e'(opcode[2:1]);
      ctl.word     = opcode[0];
   end
endmodule

// File: rtl/bitop_index.sv
`timescale 1ns/1ps
module bitop_index #(
   parameter int DATA_W = 16,
   localparam int IDX_W  = $clog2(DATA_W),
   localparam int BIDX_W = $clog2(DATA_W / 2)
) (
   input  logic [IDX_W-1:0] count_idx,
   input  logic [IDX_W-1:0] imm_idx,
   input  logic             from_imm,
   input  logic             word,
   output logic [IDX_W-1:0] idx
);
   logic [IDX_W-1:0] src;

   assign src = from_imm ? imm_idx : count_idx;

   generate
      for (genvar b = 0; b < IDX_W; b++) begin : g_bit
         if (b < BIDX_W) begin : g_always
            assign idx[b] = src[b];
         end else begin : g_word_only
            assign idx[b] = src[b] & word;
         end
      end
   endgenerate

   always_comb begin
      if (!word) begin
         AST_BYTE_IDX_RANGE: assert (idx < IDX_W'(DATA_W / 2)); // R2
      end
   end
endmodule

// File: rtl/bitop_alu.sv
`timescale 1ns/1ps
module bitop_alu
   import bitop_pkg::*;
#(
   parameter int DATA_W = 16,
   localparam int IDX_W  = $clog2(DATA_W),
   localparam int BYTE_W = DATA_W / 2
) (
   input  logic [DATA_W-1:0] operand,
   input  logic [IDX_W-1:0]  idx,
   input  bop_e              op,
   input  logic              word,
   output logic [DATA_W-1:0] result,
   output logic              bit_zero
);
   logic [DATA_W-1:0] hit;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_lane
         logic lane_out;
         assign hit[i] = (idx == IDX_W'(i));
         always_comb begin
            case (op)
               BOP_CLR: lane_out = operand[i] & ~hit[i];
               BOP_SET: lane_out = operand[i] |  hit[i];
               BOP_INV: lane_out = operand[i] ^  hit[i];
               default: lane_out = operand[i];
            endcase
         end
         if (i < BYTE_W) begin : g_low
            assign result[i] = lane_out;
         end else begin : g_high
            assign result[i] = lane_out & word;
         end
      end
   endgenerate

   assign bit_zero = ~|(operand & hit);
endmodule

// File: rtl/bitop_seq.sv
`timescale 1ns/1ps
module bitop_seq #(
   parameter int LAT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             is_mem,
   input  logic             needs_write,
   input  logic [LAT_W-1:0] first_cnt,
   input  logic             mem_ack,
   output logic             busy,
   output logic             done,
   output logic             capture,
   output logic             mem_req,
   output logic             mem_we
);
   typedef enum logic [1:0] {PH_IDLE, PH_RD, PH_WR, PH_FIN} phase_e;

   phase_e           phase;
   logic [LAT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else if (launch) begin
         phase <= is_mem ? PH_RD : PH_FIN;
         cnt   <= first_cnt;
      end else begin
         if (phase != PH_IDLE && cnt != '0) cnt <= cnt - 1'b1;
         case (phase)
            PH_RD:   if (mem_ack) phase <= needs_write ? PH_WR : PH_FIN;
            PH_WR:   if (mem_ack) phase <= PH_FIN;
            PH_FIN:  if (cnt == '0) phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy    = (phase != PH_IDLE);
   assign done    = (phase == PH_FIN) && (cnt == '0);
   assign mem_req = (phase == PH_RD) || (phase == PH_WR);
   assign mem_we  = (phase == PH_WR);
   assign capture = (phase == PH_RD) && mem_ack;

   AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we) |-> $past(mem_req && !mem_we && mem_ack)); // R7
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy); // R9
endmodule

// File: rtl/bitop_unit.sv
`timescale 1ns/1ps
module bitop_unit
   import bitop_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int OPC_W  = 8,
   parameter int LAT_W  = 5,
   localparam int IDX_W  = $clog2(DATA_W),
   localparam int BYTE_W = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OPC_W-1:0]  opcode,
   input  logic              use_mem,
   input  logic [DATA_W-1:0] reg_operand,
   input  logic [IDX_W-1:0]  count_idx,
   input  logic [IDX_W-1:0]  imm_idx,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_word,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] result,
   output logic              wb_en,
   output logic              zero
);
   generate
      if (DATA_W < 4 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("bitop_unit: DATA_W must be a power of two of at least 4");
      end
      if ((1 << LAT_W) <= BOP_MAX_CYCLES) begin : g_bad_lat
         $error("bitop_unit: LAT_W too small for the cycle table");
      end
   endgenerate

   bop_ctl_t          ctl_in, ctl_q;
   logic              mem_q;
   logic [IDX_W-1:0]  idx_in, idx_q;
   logic [DATA_W-1:0] opnd_q;
   logic [DATA_W-1:0] alu_out;
   logic              bit_zero;
   logic              zf_q;
   logic              launch;
   logic              capture;
   logic [LAT_W-1:0]  first_cnt;
   logic [DATA_W-1:0] low_mask;

   assign low_mask = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};

   bitop_decode #(.OPC_W(OPC_W)) u_decode (
      .opcode (opcode),
      .ctl    (ctl_in)
   );

   bitop_index #(.DATA_W(DATA_W)) u_index (
      .count_idx (count_idx),
      .imm_idx   (imm_idx),
      .from_imm  (ctl_in.from_imm),
      .word      (ctl_in.word),
      .idx       (idx_in)
   );

   assign launch    = start && ctl_in.legal && !busy;
   assign first_cnt = LAT_W'(bop_cycles(ctl_in.op, ctl_in.from_imm, ctl_in.word, use_mem) - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         mem_q  <= 1'b0;
         idx_q  <= '0;
         opnd_q <= '0;
      end else if (launch) begin
         ctl_q  <= ctl_in;
         mem_q  <= use_mem;
         idx_q  <= idx_in;
         opnd_q <= use_mem ? '0 : (ctl_in.word ? reg_operand : (reg_operand & low_mask));
      end else if (capture) begin
         opnd_q <= ctl_q.word ? mem_rdata : (mem_rdata & low_mask);
      end
   end

   bitop_seq #(.LAT_W(LAT_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch      (launch),
      .is_mem      (use_mem),
      .needs_write (ctl_q.op != BOP_TEST),
      .first_cnt   (first_cnt),
      .mem_ack     (mem_ack),
      .busy        (busy),
      .done        (done),
      .capture     (capture),
      .mem_req     (mem_req),
      .mem_we      (mem_we)
   );

   bitop_alu #(.DATA_W(DATA_W)) u_alu (
      .operand  (opnd_q),
      .idx      (idx_q),
      .op       (ctl_q.op),
      .word     (ctl_q.word),
      .result   (alu_out),
      .bit_zero (bit_zero)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                              zf_q <= 1'b0;
      else if (done && ctl_q.op == BOP_TEST)   zf_q <= bit_zero;
   end

   assign result    = alu_out;
   assign mem_wdata = alu_out;
   assign mem_word  = ctl_q.word;
   assign wb_en     = done && !mem_q && (ctl_q.op != BOP_TEST);
   assign zero      = zf_q;

   AST_ONE_BIT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ctl_q.op != BOP_TEST && ctl_q.op != BOP_INV) |-> $countones(result ^ opnd_q) <= 1); // R4
   AST_INV_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ctl_q.op == BOP_INV) |-> $countones(result ^ opnd_q) == 1); // R4
   AST_TEST_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ctl_q.op == BOP_TEST) |-> (result == opnd_q) && !wb_en); // R3
   AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !ctl_q.word) |-> result[DATA_W-1:BYTE_W] == '0); // R4
   AST_ZF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ctl_q.op != BOP_TEST) |=> $stable(zero)); // R10
   AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(ctl_q)); // R9
   AST_WB_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> done && !mem_req); // R8
endmodule

// File: tb/test_bitop_unit.sv
`timescale 1ns/1ps
module test_bitop_unit;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [7:0]    opcode = '0;
   logic          use_mem = 1'b0;
   logic [DW-1:0] reg_operand = '0;
   logic [3:0]    count_idx = '0;
   logic [3:0]    imm_idx = '0;
   logic          mem_req, mem_we, mem_word, mem_ack;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          busy, done, wb_en, zero;
   logic [DW-1:0] result;

   always #10 clk = ~clk;

   bitop_unit i_bitop_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .use_mem(use_mem),
      .reg_operand(reg_operand), .count_idx(count_idx), .imm_idx(imm_idx),
      .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
      .result(result), .wb_en(wb_en), .zero(zero)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // memory model with programmable wait cycles
   int ack_delay = 0;
   int wcnt = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_word = 1'b0;
   logic          rd_word = 1'b0;
   assign mem_ack = mem_req && (wcnt == ack_delay);
   always @(posedge clk) begin
      if (mem_req && !mem_ack) wcnt <= wcnt + 1;
      else                     wcnt <= 0;
      if (mem_req && mem_ack) begin
         if (mem_we) begin
            wr_cnt  <= wr_cnt + 1;
            wr_data <= mem_wdata;
            wr_word <= mem_word;
         end else begin
            rd_cnt  <= rd_cnt + 1;
            rd_word <= mem_word;
         end
      end
   end

   typedef struct {
      int            due;
      logic [DW-1:0] res;
      bit            wb;
      bit            tst;
      bit            mem;
      bit            word;
      bit            zfn;
      int            rd0;
      int            wr0;
   } exp_t;
   exp_t q[$];

   int n_chk = 0;
   int n_bad = 0;
   bit zf_model = 1'b0;
   bit zf_pending = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor: pops expected items as completions appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (zf_pending) begin
            chk(zero === zf_model, "R3", "zero flag (R10 for non-test)", 32'(zero), 32'(zf_model));
            zf_pending = 1'b0;
         end
         if (wb_en && !done) chk(1'b0, "R8", "wb_en outside done", 1, 0);
         if (done) begin
            if (q.size() == 0) begin
               chk(1'b0, "R9", "unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(cyc == e.due, e.mem ? "R6" : "R5", "done cycle", 32'(cyc), 32'(e.due));
               chk(result === e.res, e.tst ? "R3" : "R4", "result", 32'(result), 32'(e.res));
               chk(wb_en === e.wb, "R8", "wb_en", 32'(wb_en), 32'(e.wb));
               chk(rd_cnt - e.rd0 == (e.mem ? 1 : 0), "R7", "read count",
                   32'(rd_cnt - e.rd0), e.mem ? 1 : 0);
               chk(wr_cnt - e.wr0 == ((e.mem && !e.tst) ? 1 : 0), "R7", "write count",
                   32'(wr_cnt - e.wr0), (e.mem && !e.tst) ? 1 : 0);
               if (e.mem) chk(rd_word === e.word, "R7", "read width", 32'(rd_word), 32'(e.word));
               if (e.mem && !e.tst) begin
                  chk(wr_data === e.res, "R7", "write data", 32'(wr_data), 32'(e.res));
                  chk(wr_word === e.word, "R7", "write width", 32'(wr_word), 32'(e.word));
               end
               if (e.tst) zf_model = e.zfn;
               zf_pending = 1'b1;
            end
         end
      end
   end

   function automatic int table_n(input int op, input bit imm, input bit w, input bit mem);
      int n;
      if (!mem) begin
         n = (op == 0) ? 3 : (op == 1) ? 5 : 4;
         return n + (imm ? 1 : 0);
      end
      case (op)
         0: n = imm ? (w ? 17 : 13) : (w ? 16 : 12);
         1: n = imm ? (w ? 27 : 15) : (w ? 22 : 14);
         2: n = imm ? (w ? 22 : 14) : (w ? 21 : 13);
         default: n = imm ? (w ? 27 : 19) : (w ? 26 : 18);
      endcase
      return n;
   endfunction

   // driver: launch one operation and push what it must produce
   task automatic run_op(input logic [7:0] opc, input bit mem, input logic [DW-1:0] val,
                         input logic [3:0] cidx, input logic [3:0] iidx, input int dly,
                         input bit poke_busy);
      exp_t e;
      int op, idx, n, need;
      bit imm, w, b;
      logic [DW-1:0] v;
      op  = int'(opc[2:1]);
      imm = opc[3];
      w   = opc[0];
      idx = int'(imm ? iidx : cidx) & (w ? 15 : 7);
      v   = w ? val : (val & 16'h00FF);
      b   = v[idx];
      case (op)
         1: v[idx] = 1'b0;
         2: v[idx] = 1'b1;
         3: v[idx] = ~v[idx];
         default: ;
      endcase
      n = table_n(op, imm, w, mem);
      if (mem) begin
         need = (op == 0) ? 2 + dly : 3 + 2 * dly;
         if (need > n) n = need;
      end
      @(negedge clk);
      ack_delay   = dly;
      opcode      = opc;
      use_mem     = mem;
      reg_operand = mem ? ~val : val;
      mem_rdata   = mem ? val : ~val;
      count_idx   = cidx;
      imm_idx     = iidx;
      e.due  = cyc + n;
      e.res  = v;
      e.wb   = !mem && (op != 0);
      e.tst  = (op == 0);
      e.mem  = mem;
      e.word = w;
      e.zfn  = !b;
      e.rd0  = rd_cnt;
      e.wr0  = wr_cnt;
      q.push_back(e);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke_busy) begin
         @(negedge clk);
         opcode = 8'h1F;
         reg_operand = 16'h0000;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait (q.size() == 0);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(!busy && !done && !mem_req && !wb_en && !zero, "R9", "reset outputs",
          {27'd0, busy, done, mem_req, wb_en, zero}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R3 R4 R5 R8: every register form
      for (int op = 0; op < 4; op++)
         for (int s = 0; s < 2; s++)
            for (int w = 0; w < 2; w++)
               run_op({4'b0001, 1'(s), 2'(op), 1'(w)}, 1'b0,
                      16'hA5C3 ^ 16'(op * 16'h1357 + s * 16'h0F0F),
                      4'(op * 5 + w * 3 + 9), 4'(op * 3 + s * 7 + w), 0, 1'b0);

      // R2: high source bits must be dropped for byte, kept for word
      run_op(8'h14, 1'b0, 16'hFF00, 4'hD, 4'h0, 0, 1'b0);   // set, count, byte -> bit 5
      run_op(8'h1D, 1'b0, 16'h0000, 4'h0, 4'hF, 0, 1'b0);   // set, imm, word -> bit 15
      run_op(8'h18, 1'b0, 16'hFF7F, 4'h0, 4'hF, 0, 1'b0);   // test, imm, byte -> bit 7 = 0
      run_op(8'h13, 1'b0, 16'h8000, 4'hF, 4'h0, 0, 1'b0);   // clear, count, word -> bit 15

      // R6 R7: every memory form, zero-wait memory
      for (int op = 0; op < 4; op++)
         for (int s = 0; s < 2; s++)
            for (int w = 0; w < 2; w++)
               run_op({4'b0001, 1'(s), 2'(op), 1'(w)}, 1'b1,
                      16'h3C69 ^ 16'(op * 16'h2468 + w * 16'h8181),
                      4'(op * 7 + s + 4), 4'(op + s * 5 + w * 9), 0, 1'b0);

      // R11: slow memory stretches past the table count
      run_op(8'h10, 1'b1, 16'h0001, 4'h0, 4'h0, 15, 1'b0);  // test byte: 17 > 12
      run_op(8'h1B, 1'b1, 16'hFFFF, 4'h0, 4'hA, 14, 1'b0);  // clear word imm: 31 > 27
      run_op(8'h13, 1'b1, 16'h1234, 4'h2, 4'h0, 3, 1'b0);   // clear word: 22 stays

      // R9: start while busy is ignored
      run_op(8'h16, 1'b0, 16'h0000, 4'h1, 4'h0, 0, 1'b1);
      repeat (40) @(negedge clk);
      chk(!busy, "R9", "busy after ignored start", 32'(busy), 0);

      // R1: illegal group code never launches
      begin
         bit seen;
         seen = 1'b0;
         @(negedge clk);
         opcode = 8'h2A;
         use_mem = 1'b0;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (40) begin
            if (busy || done) seen = 1'b1;
            @(negedge clk);
         end
         chk(!seen, "R1", "illegal opcode launched", 32'(seen), 0);
      end

      // R10: zero flag survives a modifying op after a test that set it
      run_op(8'h10, 1'b0, 16'h0000, 4'h2, 4'h0, 0, 1'b0);
      run_op(8'h17, 1'b0, 16'h0000, 4'h2, 4'h0, 0, 1'b0);
      run_op(8'h10, 1'b0, 16'h0004, 4'h2, 4'h0, 0, 1'b0);
      run_op(8'h12, 1'b1, 16'h0000, 4'h3, 4'h0, 0, 1'b0);

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end
endmodule